// File: doc/BRIEF.md
# Quad DAC Register Update Controller

This block is the digital register path of a four-channel, 12-bit serial-input DAC. A host shifts 24-bit frames in over a serial clock while a frame-select line is held low. Each frame writes one of three things: a channel's input register, a per-channel output range setting, or a power or control setting. Input registers are copied into the DAC registers that drive the converters. The copy happens either right away for the addressed channel, or later for all channels at once on a falling edge of a load line. Which of the two applies depends on the level of the load line while the frame is shifted in.

A level-sensitive, active-low clear input forces every DAC register to zero-scale or midscale. While the clear is low it also blocks every update. The same clear can be issued as a command frame. Writes to channels that are powered down are dropped. On bipolar ranges a pin can select two's-complement input codes, which are turned into the offset-binary form the converter uses before they reach the DAC register. All serial and control inputs are sampled on the system clock, which must run well above the serial clock rate.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After synchronous reset every DAC register reads 0x000, every channel is powered down, the clear select is zero-scale and every range code is 0.
- R2: A frame is 24 bits, shifted in MSB first and sampled on falling sclk while sync_n is low. Bit 23 is 1 for a read and 0 for a write. Bits 22:19 hold the register select: 0 = input data, 1 = range, 2 = power, 3 = control. Bits 18:16 hold the channel (0 to 3, or 4 for all channels), and bits 15:0 hold the data, with a 12-bit code in bits 15:4. With ldac_n low at the end of the frame, a data write updates the addressed channel's DAC register after the rising edge of sync_n.
- R3: With ldac_n high at the end of the frame, a data write changes only the input register. A later falling edge of ldac_n, taken while sync_n is high, copies every input register into its DAC register.
- R4: Channel code 4 on a data write addresses every powered channel at once.
- R5: A power frame sets channel i powered when data bit i is 1 (shown on chan_pwr). A data write to a powered-down channel changes neither its input register nor its DAC register.
- R6: A frame that ends with any sclk falling-edge count other than 24 changes no register.
- R7: While clr_n is low, every DAC register holds the clear code and no update takes effect. The clear code is 0x000 when control bit 0 is 0 and 0x800 when it is 1; that bit is written by a control frame with channel code 1. After clr_n returns high, the clear code is held until a new update.
- R8: A control frame with channel code 4 clears every DAC register to the clear code.
- R9: Range codes 0 to 2 are unipolar and 3 to 5 are bipolar, set per channel by a range frame (data bits 2:0). On a bipolar channel with twos_comp high, the MSB of the code is inverted on its way into the DAC register. In every other case the code is stored unchanged.
- R10: A read frame (bit 23 = 1) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| sync_n | input | 1 | Frame select, active low |
| sdin | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Load line: mode select during a frame, group load on falling edge |
| clr_n | input | 1 | Active-low clear, level sensitive |
| twos_comp | input | 1 | 1 = bipolar codes arrive in two's complement |
| dac_codes | output | 48 | DAC registers, channel i in bits 12*i+11:12*i |
| chan_pwr | output | 4 | Per-channel power-up state |

## Verification
The immediate-update path is swept over every channel with codes at both ends of the scale, single-bit patterns and per-channel distinct values. This separates a wrong channel decode or a shifted field from a correct load. Every range code is crossed with both twos_comp levels and with codes whose MSB is 0 and 1, so a conversion applied on the wrong ranges or in the wrong direction shows up. Deferred loads use a distinct value per channel, which separates a group load from a single-channel load and shows any update that leaks early. Short, long and read frames, powered-down writes and both clear sources are each followed by an observation that could only differ if the ignored stimulus had changed state.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

  typedef enum logic [3:0] {
    SEL_DATA  = 4'd0,
    SEL_RANGE = 4'd1,
    SEL_POWER = 4'd2,
    SEL_CTRL  = 4'd3
  } reg_sel_e;

  localparam int CH_W     = 3;
  localparam int RNG_W    = 3;
  localparam logic [CH_W-1:0] CH_ALL   = 3'd4;
  localparam logic [CH_W-1:0] CTRL_CFG = 3'd1;
  localparam logic [CH_W-1:0] CTRL_CLR = 3'd4;

  // Range codes at or above 3 are bipolar
  function automatic logic is_bipolar(input logic [RNG_W-1:0] rng);
    return rng >= 3'd3;
  endfunction

endpackage

// File: rtl/quad_dac_shifter.sv
module quad_dac_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               sync_n,
  input  logic               sdin,
  input  logic               ldac_n,
  output logic               frame_stb,
  output logic [FRAME_W-1:0] frame_q,
  output logic               frame_ldac
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_d, sync_d;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  wire sclk_fall = sclk_d & ~sclk;
  wire sync_fall = sync_d & ~sync_n;
  wire sync_rise = ~sync_d & sync_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      sync_d     <= 1'b1;
      sh         <= '0;
      cnt        <= '0;
      frame_stb  <= 1'b0;
      frame_q    <= '0;
      frame_ldac <= 1'b1;
    end else begin
      sclk_d     <= sclk;
      sync_d     <= sync_n;
      frame_stb  <= sync_rise && (cnt == CNT_FULL);
      frame_ldac <= ldac_n;
      if (sync_rise) frame_q <= sh;
      if (sync_fall) begin
        cnt <= '0;
      end else if (!sync_n && sclk_fall) begin
        sh <= {sh[FRAME_W-2:0], sdin};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/quad_dac_chan.sv
module quad_dac_chan
  import quad_dac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_in,
  input  logic              wr_now,
  input  logic              ld_all,
  input  logic              clr,
  input  logic [DATA_W-1:0] clr_code,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_rng,
  input  logic [RNG_W-1:0]  rng_in,
  input  logic              twos_comp,
  output logic [DATA_W-1:0] dac_q
);
  logic [DATA_W-1:0] in_q;
  logic [RNG_W-1:0]  rng_q;

  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  wire flip = is_bipolar(rng_q) & twos_comp;
  wire [DATA_W-1:0] now_code  = flip ? (din ^ MSB_MASK) : din;
  wire [DATA_W-1:0] held_code = flip ? (in_q ^ MSB_MASK) : in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      rng_q <= '0;
      dac_q <= '0;
    end else begin
      if (wr_in)  in_q  <= din;
      if (wr_rng) rng_q <= rng_in;
      if (clr)         dac_q <= clr_code;
      else if (wr_now) dac_q <= now_code;
      else if (ld_all) dac_q <= held_code;
    end
  end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import quad_dac_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclk,
  input  logic                     sync_n,
  input  logic                     sdin,
  input  logic                     ldac_n,
  input  logic                     clr_n,
  input  logic                     twos_comp,
  output logic [NUM_CH*DATA_W-1:0] dac_codes,
  output logic [NUM_CH-1:0]        chan_pwr
);
  localparam int PAY_W   = FRAME_W - 8;
  localparam int CH_LSB  = PAY_W;
  localparam int SEL_LSB = CH_LSB + CH_W;
  localparam int RW_BIT  = FRAME_W - 1;
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic               fr_stb, fr_ldac;
  logic [FRAME_W-1:0] fr_word;
  logic               ldac_d, clr_sel_q;
  logic [NUM_CH-1:0]  pwr_q;

  quad_dac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .frame_stb(fr_stb), .frame_q(fr_word),
    .frame_ldac(fr_ldac)
  );

  wire              wr_ok = fr_stb & ~fr_word[RW_BIT];
  wire [3:0]        rsel  = fr_word[SEL_LSB +: 4];
  wire [CH_W-1:0]   ch    = fr_word[CH_LSB +: CH_W];
  wire [PAY_W-1:0]  pay   = fr_word[PAY_W-1:0];
  wire [DATA_W-1:0] code  = pay[PAY_W-1 -: DATA_W];

  wire clr_cmd   = wr_ok && rsel == SEL_CTRL && ch == CTRL_CLR;
  wire clr_force = ~clr_n | clr_cmd;
  wire ld_all    = ldac_d & ~ldac_n & sync_n & clr_n;
  wire [DATA_W-1:0] clr_code = clr_sel_q ? MID_CODE : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ldac_d    <= 1'b1;
      pwr_q     <= '0;
      clr_sel_q <= 1'b0;
    end else begin
      ldac_d <= ldac_n;
      if (wr_ok && rsel == SEL_POWER) pwr_q <= pay[NUM_CH-1:0];
      if (wr_ok && rsel == SEL_CTRL && ch == CTRL_CFG) clr_sel_q <= pay[0];
    end
  end

  assign chan_pwr = pwr_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    wire hit    = (ch == CH_W'(i)) || (ch == CH_ALL);
    wire wr_in  = wr_ok && rsel == SEL_DATA && hit && pwr_q[i];
    wire wr_rng = wr_ok && rsel == SEL_RANGE && hit;
    quad_dac_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst(rst),
      .wr_in(wr_in), .wr_now(wr_in & ~fr_ldac), .ld_all(ld_all),
      .clr(clr_force), .clr_code(clr_code), .din(code),
      .wr_rng(wr_rng), .rng_in(pay[RNG_W-1:0]), .twos_comp(twos_comp),
      .dac_q(dac_codes[i*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/quad_dac_ctrl_chk.sv
module quad_dac_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     clr_n,
  input logic                     fr_stb,
  input logic                     fr_ldac,
  input logic                     ld_all,
  input logic                     clr_force,
  input logic [NUM_CH*DATA_W-1:0] dac_codes,
  input logic [NUM_CH-1:0]        chan_pwr
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [NUM_CH*DATA_W-1:0] ALL_MID = {NUM_CH{MID}};

  // R1: reset leaves every DAC register at zero and all channels down
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (dac_codes == '0 && chan_pwr == '0));

  // R7: clear low drives every channel to one of the two clear codes
  p_clear_code_r7: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (dac_codes == '0 || dac_codes == ALL_MID));

  // R6: with no frame, no group load and no clear, DAC registers hold
  p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !(fr_stb || ld_all || clr_force) |=> $stable(dac_codes));

  // R3: a frame ended with the load line high does not touch DAC registers
  p_ldac_defer_r3: assert property (@(posedge clk) disable iff (rst)
    (fr_stb && fr_ldac && !ld_all && !clr_force) |=> $stable(dac_codes));
endmodule

bind quad_dac_ctrl quad_dac_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .fr_stb(fr_stb), .fr_ldac(fr_ldac),
  .ld_all(ld_all), .clr_force(clr_force), .dac_codes(dac_codes),
  .chan_pwr(chan_pwr)
);

// File: tb/quad_dac_ctrl_test.sv
`timescale 1ns/1ps
module quad_dac_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1;
  logic clr_n = 1'b1, twos_comp = 1'b0;
  logic [47:0] dac_codes;
  logic [3:0]  chan_pwr;

  int checks = 0;
  int errors = 0;
  int dac_m [4];
  int in_m  [4];
  int rng_m [4];

  always #2 clk = ~clk;

  quad_dac_ctrl uut (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .twos_comp(twos_comp),
    .dac_codes(dac_codes), .chan_pwr(chan_pwr)
  );

  function automatic logic [23:0] mk(input int rw, input int sel, input int ch, input int data);
    return {rw[0], sel[3:0], ch[2:0], data[15:0]};
  endfunction

  function automatic int conv(input int code, input int rng);
    return (rng >= 3 && twos_comp) ? (code ^ 'h800) : code;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int c = 0; c < 4; c++) chk(int'(dac_codes[c*12 +: 12]), dac_m[c], tag);
  endtask

  task automatic send(input logic [23:0] fr, input int nbits, input logic lv);
    @(negedge clk) sync_n = 1'b0;
    @(negedge clk) ldac_n = lv;
    for (int b = 0; b < nbits; b++) begin
      sclk = 1'b1;
      sdin = (b < 24) ? fr[23-b] : 1'b0;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (4) @(negedge clk);
    ldac_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_ldac();
    @(negedge clk) ldac_n = 1'b0;
    repeat (4) @(negedge clk);
    ldac_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // data write with bench model update
  task automatic wr_data(input int ch, input int code, input logic lv);
    send(mk(0, 0, ch, code << 4), 24, lv);
    for (int c = 0; c < 4; c++)
      if ((ch == c || ch == 4) && chan_pwr[c]) begin
        in_m[c] = code;
        if (!lv && clr_n) dac_m[c] = conv(code, rng_m[c]);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin dac_m[c] = 0; in_m[c] = 0; rng_m[c] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk_all("R1 reset dac");
    chk(int'(chan_pwr), 0, "R1 reset power");

    // R5 powered-down write dropped
    wr_data(0, 'h5A5, 1'b0);
    chk_all("R5 write to powered-down channel");
    send(mk(0, 2, 0, 'hF), 24, 1'b1);
    chk(int'(chan_pwr), 'hF, "R5 power register");
    pulse_ldac();
    chk_all("R5 input register untouched while down");

    // R2 immediate update sweep
    for (int c = 0; c < 4; c++) begin
      int pats[5] = '{'h000, 'hFFF, 'h001, 'h800, 'h123 + 'h111 * c};
      foreach (pats[k]) begin
        wr_data(c, pats[k], 1'b0);
        chk_all("R2 immediate update");
      end
    end

    // R3 deferred update
    for (int c = 0; c < 4; c++) begin
      wr_data(c, 'h321 + 'h204 * c, 1'b1);
      chk_all("R3 no update with load line high");
    end
    pulse_ldac();
    for (int c = 0; c < 4; c++) dac_m[c] = conv(in_m[c], rng_m[c]);
    chk_all("R3 group load on falling load line");

    // R4 broadcast
    wr_data(4, 'h5A5, 1'b0);
    chk_all("R4 all-channel write");
    for (int c = 0; c < 4; c++) chk(dac_m[c], 'h5A5, "R4 model");

    // R6 short and long frames
    send(mk(0, 0, 1, 'hABC << 4), 23, 1'b0);
    chk_all("R6 short frame discarded");
    send(mk(0, 0, 1, 'hABC << 4), 25, 1'b0);
    chk_all("R6 long frame discarded");
    pulse_ldac();
    chk_all("R6 input register untouched");

    // R10 read frame
    send(mk(1, 0, 2, 'h777 << 4), 24, 1'b0);
    chk_all("R10 read frame ignored");

    // R9 conversion sweep on channel 2
    for (int r = 0; r < 6; r++)
      for (int t = 0; t < 2; t++) begin
        twos_comp = t[0];
        send(mk(0, 1, 2, r), 24, 1'b1);
        rng_m[2] = r;
        wr_data(2, 'h3C7, 1'b0);
        chk(int'(dac_codes[24 +: 12]), conv('h3C7, r), "R9 conversion msb 0");
        wr_data(2, 'hC38, 1'b0);
        chk(int'(dac_codes[24 +: 12]), conv('hC38, r), "R9 conversion msb 1");
      end
    twos_comp = 1'b0;
    send(mk(0, 1, 2, 0), 24, 1'b1);
    rng_m[2] = 0;

    // R7 clear to zero-scale, blocking and holding
    @(negedge clk) clr_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 4; c++) dac_m[c] = 0;
    chk_all("R7 clear to zero-scale");
    wr_data(0, 'h123, 1'b0);
    chk_all("R7 update blocked while clear low");
    pulse_ldac();
    chk_all("R7 group load blocked while clear low");
    @(negedge clk) clr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R7 clear code held after release");
    send(mk(0, 3, 1, 1), 24, 1'b1);
    @(negedge clk) clr_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 4; c++) dac_m[c] = 'h800;
    chk_all("R7 clear to midscale");
    @(negedge clk) clr_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 clear command
    wr_data(4, 'h9E1, 1'b0);
    chk_all("R8 setup");
    send(mk(0, 3, 4, 0), 24, 1'b1);
    for (int c = 0; c < 4; c++) dac_m[c] = 'h800;
    chk_all("R8 clear command");

    // R5 power-down of one channel
    send(mk(0, 2, 0, 'h7), 24, 1'b1);
    chk(int'(chan_pwr), 'h7, "R5 power ch3 down");
    wr_data(4, 'h246, 1'b0);
    chk_all("R5 broadcast skips powered-down channel");
    send(mk(0, 2, 0, 'hF), 24, 1'b1);
    pulse_ldac();
    for (int c = 0; c < 4; c++) dac_m[c] = conv(in_m[c], rng_m[c]);
    chk_all("R5 dropped input stays old after group load");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule